// File: doc/BRIEF.md
# Pixel-clock PLL reconfiguration sequencer

This block retunes a video transmit PLL through a management write port. A single start pulse captures a 3-bit pixel-clock range code and a 2-bit color-depth code. The block then issues eight single-cycle writes. The first seven carry the feedback divider, the input divider, the three output dividers, the charge pump word and the loop bandwidth word. The eighth write triggers the retune.

Each divider count is split into a high byte and a low byte. The third output divider is the second output divider scaled by the depth factor. After the trigger, the block watches the PLL's waitrequest line through a synchronizer. It waits for that line to rise and then to fall before it reports completion. A timeout counter covers the whole operation, from the first write to the fall of waitrequest. If the counter expires, the block aborts and raises a sticky timeout flag.

Top module: `pixpll_retune`

## Requirements
- R1: While reset is held, and in the first cycle after it, wr_o, addr_o, wdata_o, done_o and timeout_o are all 0.
- R2: A start pulse is accepted only while the block is idle. The codes are captured at that edge. Eight writes follow: write k has wr_o high for exactly one cycle, the k-th cycle pair after the accepting edge (cycle 2k), with one idle cycle between writes. The addresses are, in order, 0x90, 0xA0, 0xC0, 0xC1, 0xC2, 0x20, 0x40 and 0x00. When wr_o is low, addr_o and wdata_o are 0.
- R3: A divide count K is written as wdata_o[15:8] = ceil(K/2) and wdata_o[7:0] = floor(K/2), with all upper bits 0. Example: 75 is written as 0x2625.
- R4: The range codes select the feedback, C0 and C1 counts as follows: code 0 gives 30, 6, 60; code 1 gives 20, 4, 40; code 2 gives 10, 2, 20; code 3 gives 8, 8, 16; code 4 gives 8, 4, 8; codes 5 to 7 give 8, 2, 4. The input divider word at 0xA0 is always 0x00010000.
- R5: The C2 count at 0xC2 is C1 scaled by the depth code: 0 gives 1x, 1 gives 1.25x, 2 gives 1.5x and 3 gives 2x.
- R6: The charge pump word at 0x20 is 0x0B for range 1 and 0x10 for all other ranges. The bandwidth word at 0x40 is 0x100 for range 0 and 0xC0 for all other ranges.
- R7: The last write goes to address 0x00 with data 0x00000001.
- R8: After the trigger write, done_o rises only after waitrequest has been seen high and then low through a 3-stage synchronizer. done_o rises at the 4th rising edge that samples wreq_i low.
- R9: If waitrequest has not fallen within TIMEOUT_CYCLES edges of the accepting edge, the block returns to idle with no further writes. timeout_o then rises at exactly that edge count, and done_o stays 0.
- R10: done_o and timeout_o hold their value until the next accepted start, and both are 0 in the cycle after it.
- R11: A start pulse or a code change while the block is busy has no effect on the writes in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, sampled while idle |
| range_i | input | 3 | Pixel-clock range code |
| depth_i | input | 2 | Color-depth code |
| wreq_i | input | 1 | PLL waitrequest, asynchronous |
| wr_o | output | 1 | Management write strobe |
| addr_o | output | ADDR_W | Management write address |
| wdata_o | output | DATA_W | Management write data |
| done_o | output | 1 | Sticky completion flag |
| timeout_o | output | 1 | Sticky timeout flag |

## Verification
The bench targets the odd divide counts, where a design that rounds the wrong way would swap the high and low bytes (0x2526 in place of 0x2625). It also targets depth code 3 on the lowest range, where C2 reaches 120 and an undersized multiplier would wrap.

Two timeout cases are covered. In one, waitrequest never rises; in the other, it rises and sticks high. A design that skipped the high phase, or that counted the window wrongly, would report completion, or would flag the timeout one edge early or one edge late.

The bench also sends start pulses and changes the codes in the middle of a sequence. A design that restarted, or that read the live codes, would write different words. The exact edge on which done_o rises exposes a synchronizer that is shorter or longer than three stages.

// File: rtl/pixpll_pkg.sv
// Shared types and helpers for the pixel-clock PLL retune sequencer.
// Assumes divide counts fit in 8 bits (largest used is 120).
package pixpll_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_GAP,
        ST_WAIT_HI,
        ST_WAIT_LO
    } seq_state_t;

    localparam int NUM_WRITES = 8;

    // Split a divide count into {high byte, low byte}, high taking the odd unit.
    function automatic logic [15:0] split_count(input logic [7:0] k);
        logic [8:0] hi;
        logic [7:0] lo;
        hi = ({1'b0, k} + 9'd1) >> 1;
        lo = k >> 1;
        return {hi[7:0], lo};
    endfunction

endpackage

// File: rtl/pixpll_sync.sv
// Multi-stage synchronizer for one asynchronous level.
// Assumes STAGES >= 2; output resets low.
module pixpll_sync #(
    parameter int STAGES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] shreg;

    // Shift the sampled level through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= {shreg[STAGES-2:0], d};
    end

    assign q = shreg[STAGES-1];
endmodule

// File: rtl/pixpll_words.sv
// Combinational table giving the address and data of each write step.
// Assumes ADDR_W >= 8 and DATA_W >= 17; step 7 is the trigger.
module pixpll_words #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 32,
    parameter int STEP_W = 3
) (
    input  logic [STEP_W-1:0] step,
    input  logic [2:0]        range_code,
    input  logic [1:0]        depth_code,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);
    import pixpll_pkg::*;

    logic [7:0] m_cnt, c0_cnt, c1_cnt, c2_cnt;
    logic [9:0] scale, c2_wide;
    logic [7:0] cp_word;
    logic [8:0] bw_word;

    // Per-range counts and loop settings.
    always_comb begin
        case (range_code)
            3'd0:    begin m_cnt = 8'd30; c0_cnt = 8'd6; c1_cnt = 8'd60; end
            3'd1:    begin m_cnt = 8'd20; c0_cnt = 8'd4; c1_cnt = 8'd40; end
            3'd2:    begin m_cnt = 8'd10; c0_cnt = 8'd2; c1_cnt = 8'd20; end
            3'd3:    begin m_cnt = 8'd8;  c0_cnt = 8'd8; c1_cnt = 8'd16; end
            3'd4:    begin m_cnt = 8'd8;  c0_cnt = 8'd4; c1_cnt = 8'd8;  end
            default: begin m_cnt = 8'd8;  c0_cnt = 8'd2; c1_cnt = 8'd4;  end
        endcase
        cp_word = (range_code == 3'd1) ? 8'h0B : 8'h10;
        bw_word = (range_code == 3'd0) ? 9'h100 : 9'h0C0;
    end

    // Depth scaling of C2 in quarters of C1.
    always_comb begin
        case (depth_code)
            2'd0:    scale = 10'd4;
            2'd1:    scale = 10'd5;
            2'd2:    scale = 10'd6;
            default: scale = 10'd8;
        endcase
        c2_wide = ({2'b00, c1_cnt} * scale) >> 2;
        c2_cnt  = c2_wide[7:0];
    end

    // Select the address/data pair for the current step.
    always_comb begin
        case (step)
            3'd0:    begin addr = ADDR_W'(8'h90); data = DATA_W'(split_count(m_cnt));  end
            3'd1:    begin addr = ADDR_W'(8'hA0); data = DATA_W'(32'h0001_0000);       end
            3'd2:    begin addr = ADDR_W'(8'hC0); data = DATA_W'(split_count(c0_cnt)); end
            3'd3:    begin addr = ADDR_W'(8'hC1); data = DATA_W'(split_count(c1_cnt)); end
            3'd4:    begin addr = ADDR_W'(8'hC2); data = DATA_W'(split_count(c2_cnt)); end
            3'd5:    begin addr = ADDR_W'(8'h20); data = DATA_W'(cp_word);             end
            3'd6:    begin addr = ADDR_W'(8'h40); data = DATA_W'(bw_word);             end
            default: begin addr = '0;             data = DATA_W'(1);                   end
        endcase
    end
endmodule

// File: rtl/pixpll_timer.sv
// Timeout counter: cleared on accept, counts while run is high.
// Flags expiry on the edge that completes LIMIT counted edges.
module pixpll_timer #(
    parameter int LIMIT = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = $clog2(LIMIT);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt;

    // Count busy edges since the accepting edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt <= '0;
        else if (clear)             cnt <= '0;
        else if (run && !expired)   cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == LAST);
endmodule

// File: rtl/pixpll_retune.sv
// Top of the PLL retune sequencer: accepts a start, issues eight spaced
// single-cycle writes, then waits for waitrequest to rise and fall.
// Assumes TIMEOUT_CYCLES comfortably exceeds the 15-cycle write phase.
module pixpll_retune #(
    parameter int ADDR_W         = 9,
    parameter int DATA_W         = 32,
    parameter int TIMEOUT_CYCLES = 4096,
    parameter int SYNC_STAGES    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [2:0]        range_i,
    input  logic [1:0]        depth_i,
    input  logic              wreq_i,
    output logic              wr_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              done_o,
    output logic              timeout_o
);
    import pixpll_pkg::*;

    localparam int STEP_W = $clog2(NUM_WRITES);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_WRITES - 1);

    seq_state_t        state;
    logic [STEP_W-1:0] step;
    logic [2:0]        range_q;
    logic [1:0]        depth_q;
    logic              wreq_s;
    logic              tmo_hit;
    logic              accept;
    logic [ADDR_W-1:0] word_addr;
    logic [DATA_W-1:0] word_data;

    assign accept = start_i && (state == ST_IDLE);

    pixpll_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(wreq_i), .q(wreq_s)
    );

    pixpll_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .clear(accept),
        .run(state != ST_IDLE), .expired(tmo_hit)
    );

    pixpll_words #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STEP_W(STEP_W)) u_words (
        .step(step), .range_code(range_q), .depth_code(depth_q),
        .addr(word_addr), .data(word_data)
    );

    // Sequencer state, step index, captured codes and sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            step      <= '0;
            range_q   <= '0;
            depth_q   <= '0;
            done_o    <= 1'b0;
            timeout_o <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        state     <= ST_WRITE;
                        step      <= '0;
                        range_q   <= range_i;
                        depth_q   <= depth_i;
                        done_o    <= 1'b0;
                        timeout_o <= 1'b0;
                    end
                end
                ST_WRITE: begin
                    if (tmo_hit) begin
                        state     <= ST_IDLE;
                        timeout_o <= 1'b1;
                    end else if (step == LAST_STEP) begin
                        state <= ST_WAIT_HI;
                    end else begin
                        state <= ST_GAP;
                    end
                end
                ST_GAP: begin
                    if (tmo_hit) begin
                        state     <= ST_IDLE;
                        timeout_o <= 1'b1;
                    end else begin
                        state <= ST_WRITE;
                        step  <= step + 1'b1;
                    end
                end
                ST_WAIT_HI: begin
                    if (tmo_hit) begin
                        state     <= ST_IDLE;
                        timeout_o <= 1'b1;
                    end else if (wreq_s) begin
                        state <= ST_WAIT_LO;
                    end
                end
                ST_WAIT_LO: begin
                    if (!wreq_s) begin
                        state  <= ST_IDLE;
                        done_o <= 1'b1;
                    end else if (tmo_hit) begin
                        state     <= ST_IDLE;
                        timeout_o <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Drive the write port only during a write cycle.
    always_comb begin
        wr_o    = (state == ST_WRITE);
        addr_o  = wr_o ? word_addr : '0;
        wdata_o = wr_o ? word_data : '0;
    end
endmodule

// File: rtl/pixpll_chk.sv
// Protocol checker for the retune sequencer, attached by bind.
module pixpll_chk #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wreq_i,
    input logic              wr_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic [DATA_W-1:0] wdata_o,
    input logic              done_o,
    input logic              timeout_o
);
    // R2: every write lasts one cycle and is followed by an idle cycle.
    p_write_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o |=> !wr_o);

    // R7: a write to address zero carries the trigger value.
    p_trigger_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_o && addr_o == '0) |-> (wdata_o == DATA_W'(1)));

    // R8: completion follows waitrequest low seen through the synchronizer.
    p_done_after_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> !$past(wreq_i, 4));

    // R9: a timeout never coexists with completion.
    p_flags_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && timeout_o));

    // R9: no writes issue while a terminal flag is standing.
    p_no_write_after_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || timeout_o) |-> !wr_o);
endmodule

bind pixpll_retune pixpll_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wreq_i(wreq_i), .wr_o(wr_o), .addr_o(addr_o),
    .wdata_o(wdata_o), .done_o(done_o), .timeout_o(timeout_o)
);

// File: tb/sim_pixpll_retune.sv
module sim_pixpll_retune;
    localparam int TO = 200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  range_i = '0;
    logic [1:0]  depth_i = '0;
    logic        wreq_i = 1'b0;
    logic        wr_o;
    logic [8:0]  addr_o;
    logic [31:0] wdata_o;
    logic        done_o, timeout_o;

    int checks = 0;
    int errors = 0;
    bit ended  = 0;

    always #5 clk = ~clk;

    pixpll_retune #(.ADDR_W(9), .DATA_W(32), .TIMEOUT_CYCLES(TO), .SYNC_STAGES(3)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .range_i(range_i),
        .depth_i(depth_i), .wreq_i(wreq_i), .wr_o(wr_o), .addr_o(addr_o),
        .wdata_o(wdata_o), .done_o(done_o), .timeout_o(timeout_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=0x%0h exp=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int enc(input int k);
        return (((k + 1) / 2) << 8) | (k / 2);
    endfunction

    function automatic int cnt_m(input int rg);
        case (rg) 0: return 30; 1: return 20; 2: return 10; default: return 8; endcase
    endfunction
    function automatic int cnt_c0(input int rg);
        case (rg) 0: return 6; 1: return 4; 2: return 2; 3: return 8; 4: return 4; default: return 2; endcase
    endfunction
    function automatic int cnt_c1(input int rg);
        case (rg) 0: return 60; 1: return 40; 2: return 20; 3: return 16; 4: return 8; default: return 4; endcase
    endfunction

    function automatic logic [8:0] exp_addr(input int k);
        case (k) 0: return 9'h90; 1: return 9'hA0; 2: return 9'hC0; 3: return 9'hC1;
                 4: return 9'hC2; 5: return 9'h20; 6: return 9'h40; default: return 9'h00; endcase
    endfunction

    function automatic logic [31:0] exp_data(input int k, input int rg, input int dp);
        int c2;
        c2 = (dp == 0) ? cnt_c1(rg) : (dp == 1) ? cnt_c1(rg) * 5 / 4 :
             (dp == 2) ? cnt_c1(rg) * 3 / 2 : cnt_c1(rg) * 2;
        case (k)
            0: return enc(cnt_m(rg));
            1: return 32'h0001_0000;
            2: return enc(cnt_c0(rg));
            3: return enc(cnt_c1(rg));
            4: return enc(c2);
            5: return (rg == 1) ? 32'h0B : 32'h10;
            6: return (rg == 0) ? 32'h100 : 32'hC0;
            default: return 32'h1;
        endcase
    endfunction

    // mode 0: respond, 1: waitrequest never rises, 2: waitrequest sticks high
    task automatic run_seq(input int rg, input int dp, input int mode, input int hd, input int hl, input bit poke);
        @(negedge clk);
        start_i = 1'b1; range_i = 3'(rg); depth_i = 2'(dp);
        @(posedge clk);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (i == 0) begin
                chk(!done_o && !timeout_o, "R10 flags clear after start", {done_o, timeout_o}, 0);
                start_i = 1'b0;
                if (poke) begin range_i = ~range_i; depth_i = ~depth_i; end
            end
            if (i % 2 == 0) begin
                chk(wr_o == 1'b1, "R2 write strobe", wr_o, 1);
                chk(addr_o == exp_addr(i / 2), "R2 address order", addr_o, exp_addr(i / 2));
                if (i / 2 == 4)      chk(wdata_o == exp_data(4, rg, dp), "R5 C2 depth word", wdata_o, exp_data(4, rg, dp));
                else if (i / 2 == 7) chk(wdata_o == 32'h1, "R7 trigger word", wdata_o, 1);
                else if (i / 2 >= 5) chk(wdata_o == exp_data(i / 2, rg, dp), "R6 loop word", wdata_o, exp_data(i / 2, rg, dp));
                else                 chk(wdata_o == exp_data(i / 2, rg, dp), "R3 R4 divider word", wdata_o, exp_data(i / 2, rg, dp));
            end else begin
                chk(wr_o == 1'b0, "R2 gap cycle", wr_o, 0);
            end
            if (poke && i == 5) start_i = 1'b1;
            if (poke && i == 7) start_i = 1'b0;
        end
        if (mode == 0) begin
            repeat (hd) begin
                @(negedge clk);
                chk(!done_o && !wr_o, "R8 no done before waitrequest", done_o, 0);
            end
            wreq_i = 1'b1;
            repeat (hl) @(negedge clk);
            chk(!done_o, "R8 no done while waitrequest high", done_o, 0);
            wreq_i = 1'b0;
            repeat (3) @(negedge clk);
            chk(!done_o, "R8 done not early", done_o, 0);
            @(negedge clk);
            chk(done_o && !timeout_o, "R8 done on 4th edge", {done_o, timeout_o}, 2);
            repeat (5) @(negedge clk);
            chk(done_o && !wr_o, "R10 done sticky", {done_o, wr_o}, 2);
        end else begin
            if (mode == 2) wreq_i = 1'b1;
            repeat (TO - 16) @(negedge clk);
            chk(!timeout_o && !done_o, "R9 no early timeout", {done_o, timeout_o}, 0);
            @(negedge clk);
            chk(timeout_o && !done_o, "R9 timeout edge", {done_o, timeout_o}, 1);
            wreq_i = 1'b0;
            repeat (6) begin
                @(negedge clk);
                chk(!wr_o && timeout_o, "R10 timeout sticky, no writes", {wr_o, timeout_o}, 1);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd7741));
        repeat (3) @(negedge clk);
        chk(!wr_o && addr_o == 0 && wdata_o == 0 && !done_o && !timeout_o, "R1 reset state", {wr_o, done_o, timeout_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!wr_o && !done_o && !timeout_o, "R1 after reset", {wr_o, done_o, timeout_o}, 0);
        for (int r = 0; r < 8; r++) run_seq(r, r % 4, 0, 2, 3, 1'b0);
        for (int d = 0; d < 4; d++) run_seq(0, d, 0, 1, 2, 1'b0);
        run_seq(1, 1, 0, 3, 4, 1'b1);   // R11 start and code changes while busy
        run_seq(2, 3, 1, 0, 0, 1'b0);   // R9 waitrequest never rises
        run_seq(5, 1, 0, 2, 2, 1'b0);   // R10 clearing of timeout flag
        run_seq(3, 2, 2, 0, 0, 1'b1);   // R9 waitrequest stuck high
        for (int n = 0; n < 24; n++)
            run_seq($urandom % 8, $urandom % 4, 0, 1 + $urandom % 5, 2 + $urandom % 5, 1'($urandom % 2));
        if (!ended) begin
            ended = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule